// File: doc/BRIEF.md
# Dual Half-Rate Interleaved Serializer

This block turns 10-bit words that have already been line-coded into a serial NRZ stream. It sends one bit per clock of the bit-rate clock `clk`. Each word is not shifted through a single full-rate register. It is split into two 5-bit lanes: the even-indexed bits go to one lane and the odd-indexed bits to the other. Each lane shifts once per half-rate cycle, which lasts two `clk` periods. A 2:1 select interleaves the two lane outputs, so the even bit goes out in the first clock of a half-rate cycle and the odd bit in the second.

The half-rate shift domain is modelled as an internal enable that fires on every second `clk` edge. The word clock is brought out as `word_tick`. It is high during the last clock of each 10-clock word period, and `word_in`/`word_valid` are sampled at the end of that clock. If no valid word is offered at that moment, the block sends the K28.5 comma character instead of repeating old data. After reset the outputs stay low until the first valid word has been taken.

Top module: `dual_lane_serializer`

## Requirements
- R1: After a word is loaded, `ser_out` carries its bits least significant first: bit 0 in the first clock, then bit 1, and so on up to bit 9 in the tenth clock.
- R2: Bits 0, 2, 4, 6, 8 feed the even lane and bits 1, 3, 5, 7, 9 feed the odd lane. `pair_out[0]` shows the even-lane bit and `pair_out[1]` the odd-lane bit. Both bits hold steady across the two clocks of a half-rate cycle.
- R3: In the first clock of each half-rate cycle `ser_out` equals `pair_out[0]`, and in the second clock it equals `pair_out[1]`.
- R4: `word_tick` is high for exactly one clock in every 10. Words sampled on consecutive ticks go out back to back, with no gap bit between them.
- R5: If `word_valid` is low when a word is taken, the idle word 10'h17C is sent. Least significant bit first, that is 0,0,1,1,1,1,1,0,1,0.
- R6: From reset until the first word taken with `word_valid` high, `ser_out` and `pair_out` are 0, including while idle words are being loaded. An asynchronous reset forces them back to 0 at once.
- R7: The first `word_tick` after reset release comes in the second clock cycle. `word_tick` is low in the first.
- R8: Changes on `word_in` and `word_valid` in clocks where `word_tick` is low have no effect on the serial stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one serial bit per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | 10 | Line-coded parallel word |
| word_valid | input | 1 | High when `word_in` holds a word to send |
| word_tick | output | 1 | Word clock: the inputs are sampled at the end of this clock |
| ser_out | output | 1 | Full-rate NRZ serial output |
| pair_out | output | 2 | Half-rate bit pair {odd, even} of the current half-rate cycle |

## Verification
The word load and the last shift of the previous word fall on the same clock edge. At that edge both lanes must replace their final bit with bit 0 and bit 1 of the new word, and the stream must show neither a repeated bit nor a dropped bit. The bench sets up this collision on every word by changing the inputs at the tick that ends the previous word. It then checks each of the ten following bits against the expected word, so a gap or an off-by-one load shows up at the first bit of the next word. Idle insertion is mixed into the same unbroken run, so a stale-data substitution is also judged at that boundary.

// File: rtl/ser_pkg.sv
package ser_pkg;
   localparam int unsigned DEF_WORD_W = 10;
   localparam logic [DEF_WORD_W-1:0] DEF_IDLE = 10'h17C;
   localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/sl_phase_seq.sv
module sl_phase_seq #(
   parameter int unsigned LANE_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase_o,
   output logic advance_o,
   output logic load_o
);
   localparam int unsigned CNT_W = (LANE_W > 1) ? $clog2(LANE_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LANE_W - 1);

   logic             phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         cnt_q   <= LAST;
      end else begin
         phase_q <= ~phase_q;
         if (phase_q) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign phase_o   = phase_q;
   assign advance_o = phase_q;
   assign load_o    = phase_q && (cnt_q == LAST);
endmodule

// File: rtl/sl_half_lane.sv
module sl_half_lane #(
   parameter int unsigned LANE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance_i,
   input  logic              load_i,
   input  logic [LANE_W-1:0] par_i,
   output logic              bit_o
);
   logic [LANE_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (advance_i) begin
         if (load_i) sh_q <= par_i;
         else        sh_q <= {1'b0, sh_q[LANE_W-1:1]};
      end
   end

   assign bit_o = sh_q[0];
endmodule

// File: rtl/dual_lane_serializer.sv
module dual_lane_serializer
   import ser_pkg::*;
#(
   parameter int unsigned          WORD_W    = DEF_WORD_W,
   parameter logic [WORD_W-1:0]    IDLE_WORD = DEF_IDLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_in,
   input  logic              word_valid,
   output logic              word_tick,
   output logic              ser_out,
   output logic [1:0]        pair_out
);
   localparam int unsigned LANE_W = WORD_W / NUM_LANES;

   if (WORD_W % NUM_LANES != 0) begin : g_bad_width
      $error("WORD_W must be even");
   end
   if (LANE_W < 2) begin : g_bad_lane
      $error("WORD_W must be at least 4");
   end

   logic              phase, advance, load;
   logic              started_q;
   logic [WORD_W-1:0] frame;
   logic [LANE_W-1:0] lane_par [NUM_LANES];
   logic [NUM_LANES-1:0] lane_bit;

   sl_phase_seq #(.LANE_W(LANE_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_o   (phase),
      .advance_o (advance),
      .load_o    (load)
   );

   assign frame = word_valid ? word_in : IDLE_WORD;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      for (genvar i = 0; i < LANE_W; i++) begin : g_bit
         assign lane_par[g][i] = frame[NUM_LANES*i + g];
      end
      sl_half_lane #(.LANE_W(LANE_W)) i_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .advance_i (advance),
         .load_i    (load),
         .par_i     (lane_par[g]),
         .bit_o     (lane_bit[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  started_q <= 1'b0;
      else if (load && word_valid) started_q <= 1'b1;
   end

   assign word_tick = load;
   assign pair_out  = started_q ? lane_bit : 2'b00;
   assign ser_out   = started_q & (phase ? lane_bit[1] : lane_bit[0]);
endmodule

// File: rtl/dual_lane_serializer_chk.sv
module dual_lane_serializer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       word_valid,
   input logic       word_tick,
   input logic       ser_out,
   input logic [1:0] pair_out
);
   logic [3:0] since_q;
   logic       seen_q;
   logic       live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         seen_q  <= 1'b0;
         live_q  <= 1'b0;
      end else begin
         if (word_tick) begin
            since_q <= '0;
            seen_q  <= 1'b1;
            if (word_valid) live_q <= 1'b1;
         end else if (since_q != 4'hF) begin
            since_q <= since_q + 1'b1;
         end
      end
   end

   // R4
   word_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && word_tick) |-> (since_q == 4'd9));

   // R6
   quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !live_q |-> (ser_out == 1'b0 && pair_out == 2'b00));

   // R3
   even_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !since_q[0]) |-> (ser_out == pair_out[0]));

   // R3
   odd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && since_q[0]) |-> (ser_out == pair_out[1]));

   // R2
   pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && since_q[0] && !word_tick && since_q != 4'hF) |-> $stable(pair_out));

   // R5
   idle_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_tick && !word_valid && live_q) |=> (pair_out == 2'b00));
endmodule

bind dual_lane_serializer dual_lane_serializer_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_valid (word_valid),
   .word_tick  (word_tick),
   .ser_out    (ser_out),
   .pair_out   (pair_out)
);

// File: tb/test_dual_lane_serializer.sv
module test_dual_lane_serializer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] word_in = '0;
   logic       word_valid = 1'b0;
   logic       word_tick;
   logic       ser_out;
   logic [1:0] pair_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [9:0] IDLE = 10'h17C;
   localparam int NVEC = 9;
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b1, 10'h2A5}, {1'b1, 10'h3FF}, {1'b0, 10'h155}, {1'b1, 10'h000},
      {1'b1, 10'h001}, {1'b1, 10'h200}, {1'b0, 10'h3C3}, {1'b0, 10'h0F0},
      {1'b1, 10'h1E6}
   };

   always #10 clk = ~clk;

   dual_lane_serializer i_dual_lane_serializer (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_in    (word_in),
      .word_valid (word_valid),
      .word_tick  (word_tick),
      .ser_out    (ser_out),
      .pair_out   (pair_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   initial begin
      logic [9:0] exp_w;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R6, R7: state right after reset release
      chk(word_tick == 1'b0, "R7 first cycle tick", word_tick, 0);
      chk(ser_out == 1'b0 && pair_out == 2'b00, "R6 reset outputs", {pair_out, ser_out}, 0);
      @(negedge clk);
      chk(word_tick == 1'b1, "R7 second cycle tick", word_tick, 1);
      // R6: idle words load while not started, outputs stay low
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         chk(ser_out == 1'b0 && pair_out == 2'b00, "R6 low before first valid",
             {pair_out, ser_out}, 0);
      end
      chk(word_tick == 1'b1, "R4 tick after ten clocks", word_tick, 1);
      // table walk: R1 R2 R3 R4 R5 R8
      for (int v = 0; v < NVEC; v++) begin
         word_valid = VEC[v][10];
         word_in    = VEC[v][9:0];
         exp_w      = VEC[v][10] ? VEC[v][9:0] : IDLE;
         for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(ser_out == exp_w[k], VEC[v][10] ? "R1 serial bit" : "R5 idle bit",
                ser_out, exp_w[k]);
            if (k % 2 == 0)
               chk(pair_out == {exp_w[k+1], exp_w[k]}, "R2 lane pair",
                   pair_out, {exp_w[k+1], exp_w[k]});
            chk(word_tick == (k == 9), "R4 tick timing", word_tick, (k == 9));
            if (k < 9) begin
               // R8: disturb inputs outside the tick
               word_in    = ~exp_w ^ 10'(k);
               word_valid = k[0];
            end
         end
      end
      // R6: asynchronous reset mid-stream
      word_valid = 1'b1;
      word_in    = 10'h3FF;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(ser_out == 1'b0 && pair_out == 2'b00 && word_tick == 1'b0,
          "R6 async reset clears", {word_tick, pair_out, ser_out}, 0);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule